// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block decides which monitored quantity the shared converter measures next. It walks a fixed loop of six conversions: temperature, supply, bias, coarse received-signal level, fine received-signal level and optical power. It issues one start pulse per slot and waits for the converter's done pulse before it moves on. Bias and power reach the converter through one monitor pin of an external laser-driver chip. The sequencer therefore asks a 3-wire serial master to flip that chip's monitor-select bit after the bias conversion and again after the power conversion. It waits for the master's done pulse before it issues the next conversion.

At power-up, either of two supply-low enables can place the block in a short loop that measures only temperature and supply. The full loop starts once a supply result is strictly above the supply-low threshold. The block does not contain the converter, the serial master or any result scaling. It presents a channel code, a start pulse, a toggle request carrying the new select value, and a marker pulse each time the loop returns to temperature.

Top module: `rr_conv_sequencer`

## Requirements
- R1: While reset is held, `conv_start`, `sel_req` and `cycle_done` stay low. The first request after reset release is a temperature conversion.
- R2: In full mode the requests repeat in this order: temperature (code 0), supply (code 1), bias (code 2), select toggle, coarse received level (code 3), fine received level (code 4), power (code 5), select toggle. The loop then returns to temperature. The codes are shown on `conv_chan` with each `conv_start`.
- R3: `conv_start` and `sel_req` are single-cycle pulses and never occur together. After a request, no further request is issued until the matching done arrives in a later cycle. A done of the other kind, or a done in the same cycle as the request, is ignored.
- R4: Each toggle request drives `sel_value` to the inverse of the locally held select bit. The bit resets to 0, the bias setting, and flips when the serial master reports done. So the first toggle after reset sends 1, and the values then alternate. Bias is always measured with the bit at 0, and power always with the bit at 1.
- R5: If `supply_lo_alarm_en` or `supply_lo_warn_en` is high in the first cycle after reset release, the block alternates between temperature and supply and issues no toggle requests.
- R6: The reduced loop ends when a supply result is strictly greater than `supply_lo_thresh`. A result that is equal to or below the threshold keeps the reduced loop. After the passing supply result, the next request is temperature, which opens a full loop.
- R7: The two enables are sampled once after reset. Changing them later has no effect on the order of requests.
- R8: `cycle_done` is a one-cycle pulse that coincides with every temperature `conv_start` except the first one after reset.
- R9: With both enables low at power-up, the full loop begins directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_lo_alarm_en | input | 1 | Supply-low alarm enabled (sampled at power-up) |
| supply_lo_warn_en | input | 1 | Supply-low warning enabled (sampled at power-up) |
| supply_lo_thresh | input | RES_W | Supply-low alarm threshold |
| conv_start | output | 1 | Conversion start pulse |
| conv_chan | output | 3 | Channel code of the requested conversion |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_result | input | RES_W | Converter result, valid with `conv_done` |
| sel_req | output | 1 | Request to the serial master to write the select bit |
| sel_value | output | 1 | Select-bit value to write (0 bias, 1 power) |
| sel_done | input | 1 | Serial master finished the write |
| cycle_done | output | 1 | Loop returned to the temperature slot |

## Verification
On every cycle the assertions check several properties. They check that requests are single pulses and never overlap an unfinished conversion or toggle, that a toggle only follows a bias or power conversion, and that toggle values alternate. They also check that bias and power see the correct select setting, that no toggle appears in the reduced loop, and that `cycle_done` only marks temperature starts. The exact order of the full loop, the threshold boundary that ends the reduced loop, the once-only sampling of the enables, and the ignoring of misplaced done pulses can only be shown by the bench's directed scenarios.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int CH_W = 3;

  localparam logic [CH_W-1:0] CH_TEMP  = 3'd0;
  localparam logic [CH_W-1:0] CH_VCC   = 3'd1;
  localparam logic [CH_W-1:0] CH_BIAS  = 3'd2;
  localparam logic [CH_W-1:0] CH_RXC   = 3'd3;
  localparam logic [CH_W-1:0] CH_RXF   = 3'd4;
  localparam logic [CH_W-1:0] CH_PWR   = 3'd5;
  localparam logic [CH_W-1:0] CH_NONE  = 3'd7;

  // Slot positions; order is the behaviour of the loop.
  typedef enum logic [2:0] {
    POS_TEMP, POS_VCC, POS_BIAS, POS_TOG_A,
    POS_RXC, POS_RXF, POS_PWR, POS_TOG_B
  } pos_t;

  typedef enum logic [1:0] {PH_INIT, PH_ISSUE, PH_WAIT} phase_t;

  function automatic logic is_toggle(pos_t p);
    return (p == POS_TOG_A) || (p == POS_TOG_B);
  endfunction

  function automatic logic [CH_W-1:0] chan_of(pos_t p);
    case (p)
      POS_TEMP: return CH_TEMP;
      POS_VCC:  return CH_VCC;
      POS_BIAS: return CH_BIAS;
      POS_RXC:  return CH_RXC;
      POS_RXF:  return CH_RXF;
      POS_PWR:  return CH_PWR;
      default:  return CH_NONE;
    endcase
  endfunction

  // Next slot: reduced loop bounces temp <-> supply, full loop steps and wraps.
  function automatic pos_t next_pos(pos_t p, logic reduced);
    logic [2:0] raw;
    raw = p;
    if (reduced) return (p == POS_TEMP) ? POS_VCC : POS_TEMP;
    return pos_t'(raw + 3'd1);
  endfunction
endpackage

// File: rtl/rrs_supply_gate.sv
module rrs_supply_gate #(
  parameter int RES_W  = 12,
  parameter bit STRICT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             alarm_en,
  input  logic             warn_en,
  input  logic             vcc_accept,
  input  logic [RES_W-1:0] result,
  input  logic [RES_W-1:0] thresh,
  output logic             reduced
);
  logic supply_good;

  generate
    if (STRICT) begin : g_strict
      assign supply_good = result > thresh;
    end else begin : g_incl
      assign supply_good = result >= thresh;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reduced <= 1'b0;
    else if (load_en)
      reduced <= alarm_en | warn_en;
    else if (reduced && vcc_accept && supply_good)
      reduced <= 1'b0;
  end
endmodule

// File: rtl/rrs_sel_track.sv
module rrs_sel_track #(
  parameter bit SEL_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= SEL_INIT;
    else if (flip) sel <= ~sel;
  end
endmodule

// File: rtl/rr_conv_sequencer.sv
module rr_conv_sequencer
  import rrs_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_lo_alarm_en,
  input  logic             supply_lo_warn_en,
  input  logic [RES_W-1:0] supply_lo_thresh,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             sel_req,
  output logic             sel_value,
  input  logic             sel_done,
  output logic             cycle_done
);
  phase_t phase_q;
  pos_t   pos_q;
  logic   started_q;
  logic   reduced_q;
  logic   sel_q;

  // Named internal events.
  logic in_issue, in_wait, tog_step;
  logic conv_accept, tog_accept, step_advance, vcc_accept, init_load;

  assign in_issue     = (phase_q == PH_ISSUE);
  assign in_wait      = (phase_q == PH_WAIT);
  assign init_load    = (phase_q == PH_INIT);
  assign tog_step     = is_toggle(pos_q);
  assign conv_accept  = in_wait && !tog_step && conv_done;
  assign tog_accept   = in_wait && tog_step && sel_done;
  assign step_advance = conv_accept || tog_accept;
  assign vcc_accept   = conv_accept && (pos_q == POS_VCC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_INIT;
      pos_q     <= POS_TEMP;
      started_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_INIT:  phase_q <= PH_ISSUE;
        PH_ISSUE: begin
          phase_q   <= PH_WAIT;
          started_q <= 1'b1;
        end
        PH_WAIT: if (step_advance) begin
          pos_q   <= next_pos(pos_q, reduced_q);
          phase_q <= PH_ISSUE;
        end
        default:  phase_q <= PH_INIT;
      endcase
    end
  end

  rrs_supply_gate #(.RES_W(RES_W), .STRICT(1'b1)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (init_load),
    .alarm_en   (supply_lo_alarm_en),
    .warn_en    (supply_lo_warn_en),
    .vcc_accept (vcc_accept),
    .result     (conv_result),
    .thresh     (supply_lo_thresh),
    .reduced    (reduced_q)
  );

  rrs_sel_track #(.SEL_INIT(1'b0)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .flip  (tog_accept),
    .sel   (sel_q)
  );

  assign conv_start = in_issue && !tog_step;
  assign conv_chan  = chan_of(pos_q);
  assign sel_req    = in_issue && tog_step;
  assign sel_value  = ~sel_q;
  assign cycle_done = in_issue && (pos_q == POS_TEMP) && started_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker
  import rrs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            conv_done,
  input logic            sel_req,
  input logic            sel_value,
  input logic            sel_done,
  input logic            cycle_done,
  input logic            reduced
);
  logic            busy_q, busy_tog_q, last_val_q;
  logic [CH_W-1:0] last_chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      busy_tog_q  <= 1'b0;
      last_val_q  <= 1'b0;
      last_chan_q <= CH_NONE;
    end else begin
      if (conv_start || sel_req) begin
        busy_q     <= 1'b1;
        busy_tog_q <= sel_req;
      end else if (busy_q && (busy_tog_q ? sel_done : conv_done)) begin
        busy_q <= 1'b0;
      end
      if (sel_req)    last_val_q  <= sel_value;
      if (conv_start) last_chan_q <= conv_chan;
    end
  end

  assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && sel_req));
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start || sel_req) |=> !(conv_start || sel_req));
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start || sel_req) |-> !busy_q);
  assert_toggle_place_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |-> (last_chan_q == CH_BIAS || last_chan_q == CH_PWR));
  assert_toggle_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |-> (sel_value != last_val_q));
  assert_bias_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && conv_chan == CH_BIAS) |-> !last_val_q);
  assert_power_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && conv_chan == CH_PWR) |-> last_val_q);
  assert_no_toggle_reduced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reduced |-> !sel_req);
  assert_cycle_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (conv_start && conv_chan == CH_TEMP));
endmodule

bind rr_conv_sequencer rrs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_done  (conv_done),
  .sel_req    (sel_req),
  .sel_value  (sel_value),
  .sel_done   (sel_done),
  .cycle_done (cycle_done),
  .reduced    (reduced_q)
);

// File: tb/tb_rr_conv_sequencer.sv
module tb_rr_conv_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 12;
  localparam int TOG        = 8;
  localparam int THR        = 100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             alarm_en = 1'b0, warn_en = 1'b0;
  logic [RES_W-1:0] thresh = RES_W'(THR);
  logic             conv_start, sel_req, sel_value, cycle_done;
  logic [2:0]       conv_chan;
  logic             conv_done = 1'b0, sel_done = 1'b0;
  logic [RES_W-1:0] conv_result = '0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  bit first_req;
  int exp_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_conv_sequencer #(.RES_W(RES_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .supply_lo_alarm_en(alarm_en), .supply_lo_warn_en(warn_en),
    .supply_lo_thresh(thresh),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result),
    .sel_req(sel_req), .sel_value(sel_value), .sel_done(sel_done),
    .cycle_done(cycle_done)
  );

  function automatic int exp_full(int i);
    case (i)
      0: return 0;  1: return 1;  2: return 2;  3: return TOG;
      4: return 3;  5: return 4;  6: return 5;  default: return TOG;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(bit al, bit wn);
    rst_n = 1'b0; alarm_en = al; warn_en = wn;
    conv_done = 1'b0; sel_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    first_req = 1'b1;
    exp_sel = 1;
  endtask

  // Called at a negedge; returns the next request (TOG for a toggle, -1 on timeout).
  task automatic get_req(output int kind, output int sval, output int cd);
    int waited;
    waited = 0;
    while (!(conv_start || sel_req) && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 50) begin
      kind = -1; sval = 0; cd = 0;
    end else begin
      kind = sel_req ? TOG : int'(conv_chan);
      sval = int'(sel_value);
      cd   = int'(cycle_done);
    end
  endtask

  task automatic respond(int kind, int res, int gap);
    repeat (gap) @(negedge clk);
    conv_result = RES_W'(res);
    if (kind == TOG) sel_done = 1'b1; else conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; sel_done = 1'b0;
  endtask

  task automatic expect_req(int exp_kind, int exp_cd, string tag, int res);
    int k, sv, cd;
    get_req(k, sv, cd);
    chk(k == exp_kind, tag, k, exp_kind);
    chk(cd == exp_cd, "R8 cycle_done mark", cd, exp_cd);
    if (k == TOG) begin
      chk(sv == exp_sel, "R4 select value", sv, exp_sel);
      exp_sel ^= 1;
    end
    first_req = 1'b0;
    respond(k, res, 1);
  endtask

  task automatic run_seq(int n, int start, string tag);
    for (int i = 0; i < n; i++) begin
      int e, k, sv, cd, ecd;
      e = exp_full((start + i) % 8);
      get_req(k, sv, cd);
      chk(k == e, tag, k, e);
      if (k == TOG) begin
        chk(sv == exp_sel, "R4 select value", sv, exp_sel);
        exp_sel ^= 1;
      end
      ecd = (e == 0 && !first_req) ? 1 : 0;
      chk(cd == ecd, "R8 cycle_done mark", cd, ecd);
      first_req = 1'b0;
      respond(k, 0, 1 + (i % 3));
    end
  endtask

  task automatic no_req_for(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!(conv_start || sel_req), tag, int'(conv_start || sel_req), 0);
    end
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0; alarm_en = 1'b0; warn_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!conv_start, "R1 conv_start low in reset", int'(conv_start), 0);
    chk(!sel_req, "R1 sel_req low in reset", int'(sel_req), 0);
    chk(!cycle_done, "R1 cycle_done low in reset", int'(cycle_done), 0);
    do_reset(1'b0, 1'b0);
    expect_req(0, 0, "R1 first request is temperature", 0);
  endtask

  task automatic t_full_loop;
    do_reset(1'b0, 1'b0);
    run_seq(17, 0, "R2 R9 full loop order");
  endtask

  task automatic t_stray_done;
    int k, sv, cd;
    do_reset(1'b0, 1'b0);
    get_req(k, sv, cd);
    chk(k == 0, "R3 first request", k, 0);
    conv_done = 1'b1; sel_done = 1'b1;   // same cycle as request: ignored
    @(negedge clk);
    conv_done = 1'b0; sel_done = 1'b0;
    chk(!(conv_start || sel_req), "R3 done during request ignored", int'(conv_start || sel_req), 0);
    no_req_for(3, "R3 no request while waiting");
    sel_done = 1'b1;                     // wrong kind while waiting
    @(negedge clk);
    sel_done = 1'b0;
    no_req_for(3, "R3 toggle done ignored during conversion");
    respond(0, 0, 1);
    expect_req(1, 0, "R3 supply follows after real done", 0);
    expect_req(2, 0, "R3 bias", 0);
    get_req(k, sv, cd);
    chk(k == TOG, "R3 toggle after bias", k, TOG);
    exp_sel ^= 1;
    repeat (2) @(negedge clk);
    conv_done = 1'b1;                    // wrong kind while toggle pending
    @(negedge clk);
    conv_done = 1'b0;
    no_req_for(3, "R3 conversion done ignored during toggle");
    respond(TOG, 0, 1);
    expect_req(3, 0, "R3 coarse level after toggle done", 0);
  endtask

  task automatic t_reduced;
    do_reset(1'b1, 1'b0);
    expect_req(0, 0, "R5 reduced temp", 0);
    expect_req(1, 0, "R5 reduced supply", THR - 1);
    expect_req(0, 1, "R5 back to temp, no bias", 0);
    expect_req(1, 0, "R5 supply again", THR);
    expect_req(0, 1, "R6 equal to threshold keeps reduced", 0);
    expect_req(1, 0, "R6 supply", THR + 1);
    expect_req(0, 1, "R6 temp opens full loop", 0);
    expect_req(1, 0, "R6 full supply", 0);
    expect_req(2, 0, "R6 bias after exit", 0);
    expect_req(TOG, 0, "R6 toggle after exit", 0);
  endtask

  task automatic t_warn_and_late;
    do_reset(1'b0, 1'b1);
    expect_req(0, 0, "R5 warn-only temp", 0);
    warn_en = 1'b0;
    expect_req(1, 0, "R5 warn-only supply", 0);
    expect_req(0, 1, "R7 reduced kept after enable drop", 0);
    expect_req(1, 0, "R7 supply", 0);
    expect_req(0, 1, "R7 still reduced", 0);
    do_reset(1'b0, 1'b0);
    expect_req(0, 0, "R9 temp", 0);
    alarm_en = 1'b1; warn_en = 1'b1;
    run_seq(8, 1, "R7 late enable ignored");
    alarm_en = 1'b0; warn_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_full_loop();
    t_stray_done();
    t_reduced();
    t_warn_and_late();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule